// File: doc/BRIEF.md
# Floating-Point Condition Branch Resolver

This block settles the outcome of branches that test one of the floating-point unit's condition bits. A decode stage hands it the branch fields, the branch's own address, the current condition bits and a flag saying whether the branch itself occupies another branch's delay slot. One clock later the block reports four results. It says whether the branch is taken. It gives the address at which execution continues after the delay slot. It says whether the delay-slot instruction must be annulled, and whether the branch is illegal and must trap.

The same condition-bit selection also serves moves that are conditional on a condition bit. In the same cycle as any branch, the block reports whether such a move should copy its source. The branch-likely forms annul their delay slot when they fall through. The ordinary forms always let the delay slot run.

Top module: `fp_cond_branch_resolver`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared after that edge: `res_valid_o`, `taken_o`, `nullify_o`, `trap_o` and `mov_en_o` are 0 and `next_pc_o` is 0. This holds even if a branch or move is presented in the same cycle.
- R2: `br_rt_i` bits 4:2 select which of the eight condition bits is tested. Bits 1:0 give the branch kind: 0 branches if the bit is 0, 1 branches if the bit is 1, 2 is the annulling form of kind 0, and 3 is the annulling form of kind 1.
- R3: A branch that is not in a delay slot is taken when the selected condition bit equals `br_rt_i[0]`. It then reports `taken_o`=1 with `next_pc_o` = `br_pc_i` + 4 + (sign-extended `br_off_i` shifted left by 2), including negative offsets.
- R4: An ordinary (kind 0 or 1) branch that is not taken reports `taken_o`=0 and `nullify_o`=0, with `next_pc_o` = `br_pc_i` + 8.
- R5: An annulling (kind 2 or 3) branch that is not taken reports `nullify_o`=1 and `next_pc_o` = `br_pc_i` + 8. `nullify_o` falls in the following cycle when no new branch is presented.
- R6: A branch presented with `in_dslot_i`=1 reports `trap_o`=1, `taken_o`=0 and `nullify_o`=0, with `next_pc_o` = `br_pc_i`, whatever the condition bits are.
- R7: `mov_en_o` is 1 in the cycle after `mov_valid_i`=1 exactly when condition bit `mov_cc_i` equals `mov_sense_i`. It is 0 after any cycle with `mov_valid_i`=0.
- R8: Branch results appear in the cycle after `br_valid_i`=1, together with `res_valid_o`=1. After a cycle with `br_valid_i`=0, `res_valid_o`, `taken_o`, `nullify_o` and `trap_o` are 0 and `next_pc_o` keeps its last value.
- R9: A branch and a move presented in the same cycle are resolved independently, each from its own condition index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_bits_i | input | 8 | Condition bits from the FP status register |
| br_valid_i | input | 1 | A condition branch is presented this cycle |
| br_rt_i | input | 5 | Branch field: condition index (4:2) and kind (1:0) |
| br_off_i | input | 16 | Signed word offset of the branch |
| br_pc_i | input | 32 | Address of the branch instruction |
| in_dslot_i | input | 1 | The branch sits in another branch's delay slot |
| mov_valid_i | input | 1 | A conditional move is presented this cycle |
| mov_cc_i | input | 3 | Condition index of the move |
| mov_sense_i | input | 1 | Bit value the move requires |
| res_valid_o | output | 1 | Branch results below are valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Address after the delay slot, or the faulting branch on trap |
| nullify_o | output | 1 | Annul the delay-slot instruction |
| trap_o | output | 1 | Illegal-instruction trap for the branch |
| mov_en_o | output | 1 | Conditional move should write its destination |

## Verification
A branch and a conditional move can be resolved in the same cycle from the same condition-bit vector. Every stimulus vector therefore pairs its branch with a move that tests a different condition index and alternates its required sense. Both the branch verdict and `mov_en_o` are judged in the one result cycle against values worked out from the vector's own condition bits. A reset held during a presented annulling branch and move shows that neither result leaks through.

// File: rtl/fpbr_pkg.sv
// Package: fpbr_pkg
// Shared types for the condition-branch resolver.
// Assumes the branch kind is the low two bits of the branch field.
package fpbr_pkg;

    // Branch kind: bit 0 is the required condition value, bit 1 marks the annulling form
    typedef enum logic [1:0] {
        BK_IF_CLEAR        = 2'd0,
        BK_IF_SET          = 2'd1,
        BK_IF_CLEAR_ANNUL  = 2'd2,
        BK_IF_SET_ANNUL    = 2'd3
    } fpbr_kind_e;

    // Verdict of one branch
    typedef struct packed {
        logic taken;
        logic nullify;
        logic trap;
    } fpbr_verdict_t;

endpackage

// File: rtl/fpbr_cond_select.sv
// Module: fpbr_cond_select
// Picks one condition bit out of NUM_COND by index, through a one-hot decode.
// Assumes an index at or above NUM_COND reads as 0.
module fpbr_cond_select #(
    parameter int NUM_COND = 8,
    localparam int IDX_W   = $clog2(NUM_COND)
) (
    input  logic [NUM_COND-1:0] cond_bits_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic                bit_o
);

    logic [NUM_COND-1:0] hit;

    // One AND term per condition bit, OR-reduced below
    for (genvar g = 0; g < NUM_COND; g++) begin : g_hit
        assign hit[g] = cond_bits_i[g] & (idx_i == IDX_W'(g));
    end

    // Merge the decoded terms into the selected bit
    assign bit_o = |hit;

endmodule

// File: rtl/fpbr_target_calc.sv
// Module: fpbr_target_calc
// Forms the taken target (pc + 4 + sext(off) * 4) and the address after the delay slot (pc + 8).
// Assumes PC_W > OFF_W + 2 and that addresses wrap modulo 2**PC_W.
module fpbr_target_calc #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 16
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  target_o,
    output logic [PC_W-1:0]  after_slot_o
);

    localparam int EXT_W = PC_W - OFF_W - 2;
    localparam logic [PC_W-1:0] SLOT_STEP  = PC_W'(4);
    localparam logic [PC_W-1:0] AFTER_STEP = PC_W'(8);

    logic [PC_W-1:0] disp;
    logic [PC_W-1:0] slot_pc;

    // Sign-extend the word offset into a byte displacement
    assign disp = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};

    // Delay-slot address is the base of the displacement
    assign slot_pc = pc_i + SLOT_STEP;

    // Taken target and fall-through past the delay slot
    assign target_o     = slot_pc + disp;
    assign after_slot_o = pc_i + AFTER_STEP;

endmodule

// File: rtl/fpbr_decide.sv
// Module: fpbr_decide
// Turns the branch kind, the selected condition bit and the delay-slot flag into a verdict.
// Assumes valid_i qualifies the whole verdict; with valid_i low every field is 0.
module fpbr_decide
    import fpbr_pkg::*;
(
    input  logic          valid_i,
    input  fpbr_kind_e    kind_i,
    input  logic          cond_bit_i,
    input  logic          in_dslot_i,
    output fpbr_verdict_t verdict_o
);

    logic want_set;
    logic annul_form;
    logic cond_met;

    // Decode the kind into required value and annulling form
    always_comb begin
        want_set   = (kind_i == BK_IF_SET) || (kind_i == BK_IF_SET_ANNUL);
        annul_form = (kind_i == BK_IF_CLEAR_ANNUL) || (kind_i == BK_IF_SET_ANNUL);
    end

    // Condition holds when the selected bit matches the required value
    assign cond_met = (cond_bit_i == want_set);

    // Build the verdict; an illegal placement overrides everything else
    always_comb begin
        verdict_o = '0;
        if (valid_i) begin
            if (in_dslot_i) begin
                verdict_o.trap = 1'b1;
            end else begin
                verdict_o.taken   = cond_met;
                verdict_o.nullify = annul_form && !cond_met;
            end
        end
    end

    // Checks on the verdict against its inputs
    always_comb begin
        a_r6_trap_alone: assert (!(verdict_o.trap && (verdict_o.taken || verdict_o.nullify)));
        if (valid_i && !in_dslot_i && !annul_form)
            a_r4_plain_never_annuls: assert (!verdict_o.nullify);
        if (verdict_o.taken)
            a_r3_taken_matches_bit: assert (cond_bit_i == want_set);
    end

endmodule

// File: rtl/fp_cond_branch_resolver.sv
// Module: fp_cond_branch_resolver
// Resolves floating-point condition branches and condition-bit moves, with results
// registered one cycle after presentation.
// Assumes the branch field holds the condition index above the two kind bits, and that
// cond_bits_i is stable during the presenting cycle.
module fp_cond_branch_resolver
    import fpbr_pkg::*;
#(
    parameter int NUM_COND = 8,
    parameter int PC_W     = 32,
    parameter int OFF_W    = 16,
    localparam int IDX_W   = $clog2(NUM_COND),
    localparam int RT_W    = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] cond_bits_i,
    input  logic                br_valid_i,
    input  logic [RT_W-1:0]     br_rt_i,
    input  logic [OFF_W-1:0]    br_off_i,
    input  logic [PC_W-1:0]     br_pc_i,
    input  logic                in_dslot_i,
    input  logic                mov_valid_i,
    input  logic [IDX_W-1:0]    mov_cc_i,
    input  logic                mov_sense_i,
    output logic                res_valid_o,
    output logic                taken_o,
    output logic [PC_W-1:0]     next_pc_o,
    output logic                nullify_o,
    output logic                trap_o,
    output logic                mov_en_o
);

    logic [IDX_W-1:0] br_idx;
    fpbr_kind_e       br_kind;
    logic             br_bit;
    logic             mov_bit;
    logic [PC_W-1:0]  target;
    logic [PC_W-1:0]  after_slot;
    fpbr_verdict_t    verdict;
    logic [PC_W-1:0]  next_pc_d;

    // Split the branch field into index and kind
    assign br_idx  = br_rt_i[RT_W-1:2];
    assign br_kind = fpbr_kind_e'(br_rt_i[1:0]);

    fpbr_cond_select #(.NUM_COND(NUM_COND)) u_br_sel (
        .cond_bits_i (cond_bits_i),
        .idx_i       (br_idx),
        .bit_o       (br_bit)
    );

    fpbr_cond_select #(.NUM_COND(NUM_COND)) u_mov_sel (
        .cond_bits_i (cond_bits_i),
        .idx_i       (mov_cc_i),
        .bit_o       (mov_bit)
    );

    fpbr_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc_i         (br_pc_i),
        .off_i        (br_off_i),
        .target_o     (target),
        .after_slot_o (after_slot)
    );

    fpbr_decide u_decide (
        .valid_i    (br_valid_i),
        .kind_i     (br_kind),
        .cond_bit_i (br_bit),
        .in_dslot_i (in_dslot_i),
        .verdict_o  (verdict)
    );

    // Choose the continuation address from the verdict
    always_comb begin
        if (verdict.trap)       next_pc_d = br_pc_i;
        else if (verdict.taken) next_pc_d = target;
        else                    next_pc_d = after_slot;
    end

    // Register the branch verdict; the address holds when no branch is presented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            taken_o     <= 1'b0;
            nullify_o   <= 1'b0;
            trap_o      <= 1'b0;
            next_pc_o   <= '0;
        end else begin
            res_valid_o <= br_valid_i;
            taken_o     <= verdict.taken;
            nullify_o   <= verdict.nullify;
            trap_o      <= verdict.trap;
            if (br_valid_i) next_pc_o <= next_pc_d;
        end
    end

    // Register the move enable
    always_ff @(posedge clk) begin
        if (!rst_n) mov_en_o <= 1'b0;
        else        mov_en_o <= mov_valid_i && (mov_bit == mov_sense_i);
    end

    // Timing and exclusivity checks on the registered outputs
    a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_i |=> res_valid_o);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid_i |=> !res_valid_o && !taken_o && !nullify_o && !trap_o && $stable(next_pc_o));

    a_r6_dslot_traps: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_i && in_dslot_i |=> trap_o && !taken_o && !nullify_o && next_pc_o == $past(br_pc_i));

    a_r5_nullify_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        nullify_o |-> res_valid_o && !taken_o && !trap_o);

    a_r4_fallthrough_addr: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid_i && !in_dslot_i |=> taken_o || next_pc_o == $past(br_pc_i) + PC_W'(8));

    a_r7_move_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mov_valid_i |=> !mov_en_o);

endmodule

// File: tb/fp_cond_branch_resolver_bench.sv
module fp_cond_branch_resolver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // Vector: rt[32:28] off[27:12] cond[11:4] dslot[3] exp_taken[2] exp_null[1] exp_trap[0]
    localparam logic [32:0] VECS [NVEC] = '{
        {5'b000_01, 16'h0004, 8'h01, 1'b0, 3'b100},
        {5'b000_00, 16'h0004, 8'h01, 1'b0, 3'b000},
        {5'b001_00, 16'hFFFC, 8'hFD, 1'b0, 3'b100},
        {5'b010_11, 16'h0010, 8'h00, 1'b0, 3'b010},
        {5'b011_10, 16'hFFF0, 8'h08, 1'b0, 3'b010},
        {5'b011_10, 16'h0008, 8'hF7, 1'b0, 3'b100},
        {5'b100_11, 16'h8000, 8'h10, 1'b0, 3'b100},
        {5'b101_01, 16'h0001, 8'hDF, 1'b0, 3'b000},
        {5'b110_11, 16'h7FFF, 8'h40, 1'b0, 3'b100},
        {5'b111_00, 16'hFFFF, 8'h7F, 1'b0, 3'b100},
        {5'b111_01, 16'h0002, 8'hFF, 1'b1, 3'b001},
        {5'b010_10, 16'h0002, 8'h00, 1'b1, 3'b001},
        {5'b101_10, 16'h0003, 8'h00, 1'b0, 3'b100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cond_bits = '0;
    logic        br_valid = 1'b0;
    logic [4:0]  br_rt = '0;
    logic [15:0] br_off = '0;
    logic [31:0] br_pc = '0;
    logic        in_dslot = 1'b0;
    logic        mov_valid = 1'b0;
    logic [2:0]  mov_cc = '0;
    logic        mov_sense = 1'b0;
    logic        res_valid, taken, nullify, trap, mov_en;
    logic [31:0] next_pc;

    int checks = 0;
    int fails  = 0;

    fp_cond_branch_resolver u_fp_cond_branch_resolver (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_bits_i (cond_bits),
        .br_valid_i  (br_valid),
        .br_rt_i     (br_rt),
        .br_off_i    (br_off),
        .br_pc_i     (br_pc),
        .in_dslot_i  (in_dslot),
        .mov_valid_i (mov_valid),
        .mov_cc_i    (mov_cc),
        .mov_sense_i (mov_sense),
        .res_valid_o (res_valid),
        .taken_o     (taken),
        .next_pc_o   (next_pc),
        .nullify_o   (nullify),
        .trap_o      (trap),
        .mov_en_o    (mov_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] pc_last;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "res_valid", {31'b0, res_valid}, 0);
        check("R1", "taken",     {31'b0, taken}, 0);
        check("R1", "nullify",   {31'b0, nullify}, 0);
        check("R1", "trap",      {31'b0, trap}, 0);
        check("R1", "mov_en",    {31'b0, mov_en}, 0);
        check("R1", "next_pc",   next_pc, 0);
        rst_n = 1'b1;
        pc_last = '0;

        // Table walk: branch plus a move on another index in the same cycle (R2, R3, R4, R5, R6, R7, R9)
        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] v;
            logic [31:0] pc, exp_pc, disp;
            logic [2:0]  midx;
            logic        msense;
            v      = VECS[i];
            pc     = 32'h0040_0000 + 32'(i) * 32'h100;
            disp   = {{14{v[27]}}, v[27:12], 2'b00};
            midx   = v[32:30] ^ 3'b101;
            msense = i[0];
            if (v[0])      exp_pc = pc;
            else if (v[2]) exp_pc = pc + 32'd4 + disp;
            else           exp_pc = pc + 32'd8;

            @(negedge clk);
            br_valid  = 1'b1;
            br_rt     = v[32:28];
            br_off    = v[27:12];
            cond_bits = v[11:4];
            in_dslot  = v[3];
            br_pc     = pc;
            mov_valid = 1'b1;
            mov_cc    = midx;
            mov_sense = msense;

            @(negedge clk);
            check("R8", "res_valid", {31'b0, res_valid}, 1);
            check(v[0] ? "R6" : "R3", "taken", {31'b0, taken}, {31'b0, v[2]});
            check(v[1] ? "R5" : "R4", "nullify", {31'b0, nullify}, {31'b0, v[1]});
            check("R6", "trap", {31'b0, trap}, {31'b0, v[0]});
            check(v[2] ? "R3" : "R4", "next_pc", next_pc, exp_pc);
            check("R9", "mov_en", {31'b0, mov_en}, {31'b0, v[4 + midx] == msense});
            br_valid  = 1'b0;
            mov_valid = 1'b0;
            pc_last   = exp_pc;

            // R8 / R5: outputs drop back, address held
            @(negedge clk);
            check("R5", "nullify after", {31'b0, nullify}, 0);
            check("R8", "res_valid after", {31'b0, res_valid}, 0);
            check("R8", "next_pc held", next_pc, pc_last);
            check("R7", "mov_en idle", {31'b0, mov_en}, 0);
        end

        // R2: every index against a single set bit, kind "branch if set"
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cond_bits = 8'h01 << 3;
            br_valid  = 1'b1;
            br_rt     = {3'(k), 2'b01};
            br_off    = 16'h0000;
            br_pc     = 32'h0000_1000;
            in_dslot  = 1'b0;
            @(negedge clk);
            check("R2", "index select", {31'b0, taken}, {31'b0, k == 3});
            br_valid = 1'b0;
        end

        // R7: move requiring a clear bit on a set bit, and requiring a set bit
        @(negedge clk);
        cond_bits = 8'h80; mov_valid = 1'b1; mov_cc = 3'd7; mov_sense = 1'b0;
        @(negedge clk);
        check("R7", "move mismatch", {31'b0, mov_en}, 0);
        mov_sense = 1'b1;
        @(negedge clk);
        check("R7", "move match", {31'b0, mov_en}, 1);
        mov_valid = 1'b0;

        // R1: reset during an annulling not-taken branch and a matching move
        @(negedge clk);
        rst_n = 1'b0; cond_bits = 8'h00; br_valid = 1'b1; br_rt = 5'b000_11;
        mov_valid = 1'b1; mov_cc = 3'd0; mov_sense = 1'b0;
        @(negedge clk);
        check("R1", "nullify in reset", {31'b0, nullify}, 0);
        check("R1", "res_valid in reset", {31'b0, res_valid}, 0);
        check("R1", "mov_en in reset", {31'b0, mov_en}, 0);
        check("R1", "next_pc in reset", next_pc, 0);
        br_valid = 1'b0; mov_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule